// File: doc/BRIEF.md
# Image Sensor Pixel Capture

This block sits in the pixel clock domain of a CMOS image sensor. It samples the sensor's frame sync, line valid and two 8-bit data channels on every rising pixel clock edge, registers them once, and only then decides whether a pixel is inside the active window. Each pixel it takes leaves as one 16-bit word carrying the luma byte above the chroma byte, offered on a valid/ready stream toward a dual-clock FIFO that moves the data into the faster system clock domain.

The block follows line structure within a frame. When raw colour mode is selected, the first active line after each frame sync is not captured. A global capture enable can suppress all output. A per-frame counter tallies the words the FIFO accepted and, at the next frame sync, publishes the total with a one-cycle strobe for the system side to pick up.

The sensor cannot be stalled, so the stream has no true back-pressure: `out_valid` is a one-cycle pulse per taken pixel and never waits for `out_ready`. A word offered while `out_ready` is low is lost and left out of the frame total. `out_ready` is the FIFO's not-full flag.

Top module: `cam_pixel_capture`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `out_valid`, `frame_done` and `frame_pixels` are all 0.
- R2: A pixel sampled at clock edge k appears with `out_valid` high after edge k+1, with `out_data[15:8]` equal to the `y_data` and `out_data[7:0]` equal to the `uv_data` sampled at edge k.
- R3: Exactly one word is produced for each edge at which `href` is sampled high and the pixel is allowed; no word is produced for edges with `href` low.
- R4: A pixel whose word would be produced while `capture_en` is low (value sampled one edge after the pixel) is dropped; with `capture_en` low, `out_valid` stays low.
- R5: With `raw_mode` high, every pixel of the first `href`-high line after a rising edge of `vsync` is dropped, and later lines of that frame are taken; each new `vsync` rise re-arms the drop.
- R6: With `raw_mode` low, the first line after `vsync` is taken like every other line.
- R7: `frame_done` pulses for one cycle two edges after a rising `vsync` is sampled, and `frame_pixels` then holds the number of words accepted since the previous rise (0 for the first rise after reset); between pulses `frame_pixels` does not change.
- R8: A word with `out_valid` high and `out_ready` low is not counted in `frame_pixels`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Sensor pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Frame sync from the sensor; a rise starts a frame |
| href | input | 1 | Line valid from the sensor |
| y_data | input | 8 | Luma channel byte |
| uv_data | input | 8 | Chroma channel byte |
| raw_mode | input | 1 | 1 = drop the first line of each frame |
| capture_en | input | 1 | 1 = allow words to be produced |
| out_valid | output | 1 | One-cycle strobe per captured word |
| out_ready | input | 1 | FIFO can take a word; a word offered while low is lost |
| out_data | output | 16 | {luma, chroma} word |
| frame_pixels | output | 20 | Accepted words in the last completed frame |
| frame_done | output | 1 | One-cycle strobe when `frame_pixels` is updated |

## Verification
The hardest case to reach from the ports is the interaction of the line skip with frame boundaries: the skip state must be re-armed by each frame sync and cleared only by the falling edge of line valid. The stimulus therefore runs several frames back to back in raw mode, each with lines of different lengths. It also mixes in frames without raw mode, a line with capture disabled and a line with the FIFO full. As a result every frame total on `frame_pixels` depends on which line was dropped, which words were suppressed and which were refused.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic {
    LINE_SKIP = 1'b0,
    LINE_KEEP = 1'b1
  } line_state_e;
endpackage

// File: rtl/cap_sync_stage.sv
module cap_sync_stage #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/cap_line_tracker.sv
module cap_line_tracker
  import cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s_vsync,
  input  logic s_href,
  input  logic raw_mode,
  output logic frame_start,
  output logic line_open
);
  logic        vs_d;
  logic        hr_d;
  logic        line_end;
  line_state_e state;

  assign frame_start = s_vsync & ~vs_d;
  assign line_end    = hr_d & ~s_href;
  assign line_open   = s_href & ~(raw_mode & (state == LINE_SKIP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_d  <= 1'b0;
      hr_d  <= 1'b0;
      state <= LINE_SKIP;
    end else begin
      vs_d <= s_vsync;
      hr_d <= s_href;
      if (frame_start)
        state <= LINE_SKIP;
      else if (line_end && state == LINE_SKIP)
        state <= LINE_KEEP;
    end
  end
endmodule

// File: rtl/cap_pixel_counter.sv
module cap_pixel_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             accept,
  output logic [CNT_W-1:0] frame_pixels,
  output logic             frame_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = (accept && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      frame_pixels <= '0;
      frame_done   <= 1'b0;
    end else begin
      frame_done <= frame_start;
      if (frame_start) begin
        frame_pixels <= cnt_inc;
        cnt          <= '0;
      end else begin
        cnt <= cnt_inc;
      end
    end
  end
endmodule

// File: rtl/cam_pixel_capture.sv
module cam_pixel_capture #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 20
) (
  input  logic               pclk,
  input  logic               rst_n,
  input  logic               vsync,
  input  logic               href,
  input  logic [PIX_W-1:0]   y_data,
  input  logic [PIX_W-1:0]   uv_data,
  input  logic               raw_mode,
  input  logic               capture_en,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [2*PIX_W-1:0] out_data,
  output logic [CNT_W-1:0]   frame_pixels,
  output logic               frame_done
);
  localparam int WORD_W = 2 * PIX_W;
  localparam int BUS_W  = WORD_W + 2;

  logic [BUS_W-1:0]  s_bus;
  logic              s_vsync;
  logic              s_href;
  logic [WORD_W-1:0] s_word;
  logic              frame_start;
  logic              line_open;
  logic              take;

  cap_sync_stage #(.W(BUS_W)) u_sync (
    .clk  (pclk),
    .rst_n(rst_n),
    .d    ({vsync, href, y_data, uv_data}),
    .q    (s_bus)
  );

  assign {s_vsync, s_href, s_word} = s_bus;

  cap_line_tracker u_track (
    .clk        (pclk),
    .rst_n      (rst_n),
    .s_vsync    (s_vsync),
    .s_href     (s_href),
    .raw_mode   (raw_mode),
    .frame_start(frame_start),
    .line_open  (line_open)
  );

  assign take = line_open & capture_en;

  always_ff @(posedge pclk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= take;
      if (take) out_data <= s_word;
    end
  end

  cap_pixel_counter #(.CNT_W(CNT_W)) u_count (
    .clk         (pclk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .accept      (out_valid & out_ready),
    .frame_pixels(frame_pixels),
    .frame_done  (frame_done)
  );
endmodule

// File: rtl/cam_pixel_capture_chk.sv
module cam_pixel_capture_chk #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 20
) (
  input logic               pclk,
  input logic               rst_n,
  input logic               vsync,
  input logic               href,
  input logic [PIX_W-1:0]   y_data,
  input logic [PIX_W-1:0]   uv_data,
  input logic               capture_en,
  input logic               out_valid,
  input logic [2*PIX_W-1:0] out_data,
  input logic [CNT_W-1:0]   frame_pixels,
  input logic               frame_done
);
  p_word_layout_r2: assert property (@(posedge pclk) disable iff (!rst_n)
    out_valid |-> out_data == {$past(y_data, 2), $past(uv_data, 2)});

  p_needs_line_r3: assert property (@(posedge pclk) disable iff (!rst_n)
    out_valid |-> $past(href, 2));

  p_enable_gate_r4: assert property (@(posedge pclk) disable iff (!rst_n)
    out_valid |-> $past(capture_en));

  p_done_single_r7: assert property (@(posedge pclk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_done_on_sync_r7: assert property (@(posedge pclk) disable iff (!rst_n)
    frame_done |-> ($past(vsync, 2) && !$past(vsync, 3)));

  p_total_held_r7: assert property (@(posedge pclk) disable iff (!rst_n)
    !frame_done |-> $stable(frame_pixels));
endmodule

bind cam_pixel_capture cam_pixel_capture_chk #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_chk (
  .pclk        (pclk),
  .rst_n       (rst_n),
  .vsync       (vsync),
  .href        (href),
  .y_data      (y_data),
  .uv_data     (uv_data),
  .capture_en  (capture_en),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .frame_pixels(frame_pixels),
  .frame_done  (frame_done)
);

// File: tb/cam_pixel_capture_tb.sv
module cam_pixel_capture_tb;
  localparam int CLK_PERIOD = 10;

  logic        pclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vsync = 1'b0;
  logic        href = 1'b0;
  logic [7:0]  y_data = '0;
  logic [7:0]  uv_data = '0;
  logic        raw_mode = 1'b0;
  logic        capture_en = 1'b1;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [15:0] out_data;
  logic [19:0] frame_pixels;
  logic        frame_done;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit first_line = 1'b1;
  bit finished = 1'b0;
  logic [15:0] word_q[$];
  int          total_q[$];

  always #(CLK_PERIOD/2) pclk = ~pclk;

  cam_pixel_capture u_dut (
    .pclk(pclk), .rst_n(rst_n), .vsync(vsync), .href(href),
    .y_data(y_data), .uv_data(uv_data), .raw_mode(raw_mode),
    .capture_en(capture_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .frame_pixels(frame_pixels), .frame_done(frame_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Frame sync: the count so far belongs to the frame now ending (R7).
  task automatic start_frame();
    total_q.push_back(exp_cnt);
    exp_cnt = 0;
    first_line = 1'b1;
    @(negedge pclk) vsync = 1'b1;
    repeat (2) @(negedge pclk);
    vsync = 1'b0;
    repeat (4) @(negedge pclk);
  endtask

  // One line of len pixels; expected words pushed by the driver (R3 R5 R6 R4 R8).
  task automatic send_line(input int len, input logic [7:0] base);
    bit keep;
    keep = capture_en && !(raw_mode && first_line);
    for (int i = 0; i < len; i++) begin
      @(negedge pclk);
      href    = 1'b1;
      y_data  = base + 8'(i);
      uv_data = ~(base + 8'(3 * i));
      if (keep) begin
        word_q.push_back({y_data, uv_data});
        if (out_ready) exp_cnt++;
      end
    end
    @(negedge pclk) href = 1'b0;
    first_line = 1'b0;
    repeat (4) @(negedge pclk);
  endtask

  // Monitor / scoreboard
  always @(negedge pclk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        if (word_q.size() == 0)
          check(1'b0, "R3/R4/R5", "unexpected word", out_data, 0);
        else begin
          logic [15:0] e;
          e = word_q.pop_front();
          check(out_data == e, "R2", "word", out_data, e);
        end
      end
      if (frame_done) begin
        if (total_q.size() == 0)
          check(1'b0, "R7", "unexpected frame_done", frame_pixels, 0);
        else begin
          int t;
          t = total_q.pop_front();
          check(frame_pixels == 20'(t), "R7/R8", "frame total", frame_pixels, t);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge pclk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge pclk);
    check(!out_valid && !frame_done && frame_pixels == 0, "R1", "in reset",
          {out_valid, frame_done}, 0);
    rst_n = 1'b1;
    @(negedge pclk);
    check(!out_valid && !frame_done && frame_pixels == 0, "R1", "after reset",
          frame_pixels, 0);

    // Frame 1: raw mode, first line dropped (R5); first total is 0
    raw_mode = 1'b1;
    start_frame();
    send_line(5, 8'h10);
    send_line(4, 8'h40);
    send_line(6, 8'h70);
    // Frame 2: raw mode again, skip re-armed (R5)
    start_frame();
    send_line(3, 8'h20);
    send_line(7, 8'hA0);
    // Frame 3: no raw mode, first line kept (R6); disabled line (R4)
    raw_mode = 1'b0;
    start_frame();
    send_line(3, 8'h30);
    capture_en = 1'b0;
    send_line(5, 8'h50);
    capture_en = 1'b1;
    send_line(2, 8'hC0);
    // Frame 4: raw mode with FIFO full on one line (R8)
    raw_mode = 1'b1;
    start_frame();
    send_line(2, 8'h01);
    out_ready = 1'b0;
    send_line(4, 8'h81);
    out_ready = 1'b1;
    send_line(3, 8'hE1);
    start_frame();
    repeat (6) @(negedge pclk);

    check(word_q.size() == 0, "R3", "words left unseen", word_q.size(), 0);
    check(total_q.size() == 0, "R7", "totals left unseen", total_q.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule